// File: doc/BRIEF.md
# Framed Serial Register Interface with Summary Status

This block is a 32-bit serial slave that gives a host controller access to a bank of control registers, a bank of sticky status registers and a small read-only identification area. Every frame begins with a command byte that holds a 2-bit opcode and a 6-bit address. The remaining three bytes carry data. While the host shifts its command in, the block shifts out a summary status byte. It then returns the content of the addressed location in the same frame, so one transaction both reads and writes.

The serial pins are sampled in the system clock domain through synchronizer stages, so the host serial clock must be a few system clocks slower per phase. The design checks each frame when chip select rises: it must have exactly 32 bits, odd parity, and a data field that is not all ones. Frames that fail are discarded. The failure is reported in the summary byte of the next frame. Status bits are set by pulses from the surrounding logic and stay set until a read-and-clear frame removes them. Each such clear is announced on a per-register strobe.

Top module: `spi_status_regif`

## Requirements
- R1: A frame is 32 bits, sent most significant bit first. Bits 31:30 hold the opcode, bits 29:24 the address, bits 23:1 the register data, and bit 0 is chosen so that the whole frame has an odd number of ones. Input bits are sampled on the serial clock rising edge. The output changes after the falling edge.
- R2: Opcode 00 (write) to a control address 01h..NUM_CTRL stores data bits 23:1 into that register. Control register at address k drives `ctrl_o[(k-1)*23 +: 23]`. All registers reset to zero.
- R3: The response frame carries the summary byte in bits 31:24 and the addressed content in bits 23:1. A write returns the content from before the write. Bit 0 of the response makes the response frame's count of ones odd.
- R4: Summary byte bit 30 is a reset flag: reset sets it and any valid frame clears it. Bit 29 is the communication error flag. Bits 28:24 mirror `flags_i[4:0]`. Bit 31 is one only when bits 30:24 are all zero.
- R5: Status register j sits at address NUM_CTRL+1+j and is read on `stat_o[j*23 +: 23]`. Opcode 01 returns it unchanged. Opcode 10 returns it, clears it when the frame ends, and pulses `stat_clr_o[j]` for one clock.
- R6: Opcode 10 to address 3Fh clears every status register and pulses every clear strobe.
- R7: Opcode 11 reads the identification area, returned in response bits 23:16 with bits 15:1 zero. Address 10h gives 31h (32-bit frame with parity), address 20h gives 55h, and any other address gives 00h.
- R8: A frame is rejected if its bit count is not 32, its parity is even, or its bits 23:0 are all ones. A rejected frame changes no register and sets the error flag. The next valid frame clears that flag.
- R9: `sdo_oe` is low while chip select is high. At each chip-select fall the output shifter reloads with the current summary byte.
- R10: A status bit set by a one-clock pulse on `stat_set_i` stays set until cleared by R5 or R6.
- R11: A write to an address outside the control range changes nothing. A read of an unmapped address returns zero data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| csn | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data from host |
| flags_i | input | 5 | Summary byte bits 28:24 |
| stat_set_i | input | NUM_STAT*23 | Set pulses for status bits |
| sdo | output | 1 | Serial data to host |
| sdo_oe | output | 1 | Output enable for the sdo pad |
| ctrl_o | output | NUM_CTRL*23 | Control register contents |
| stat_o | output | NUM_STAT*23 | Status register contents |
| stat_clr_o | output | NUM_STAT | One-clock clear strobes |

## Verification
The bench builds the block with NUM_CTRL=2 and NUM_STAT=3. This moves the status bank to 03h..05h, away from its default place. It also puts a status register directly after the last control address, so an off-by-one in the address decode either writes a status location or misses a control one. With three status registers, the test can show that a single clear leaves its neighbours intact while the 3Fh clear empties all of them. The serial clock runs ten system clocks per phase. This gives room for the synchronizer delay and the response load after the command byte.

// File: rtl/spi_rsb_pkg.sv
package spi_rsb_pkg;

    localparam int FRAME_W = 32;
    localparam int REG_W   = 23;
    localparam int ADDR_W  = 6;
    localparam int CNT_W   = 6;

    typedef enum logic [1:0] {
        OP_WRITE = 2'b00,
        OP_READ  = 2'b01,
        OP_RDCLR = 2'b10,
        OP_ROMRD = 2'b11
    } op_e;

    typedef struct packed {
        op_e               op;
        logic [ADDR_W-1:0] addr;
    } cmd_t;

    localparam logic [ADDR_W-1:0] ADDR_CLR_ALL = 6'h3F;
    localparam logic [ADDR_W-1:0] ROM_FMT_ADDR = 6'h10;
    localparam logic [ADDR_W-1:0] ROM_PHS_ADDR = 6'h20;

    function automatic logic [7:0] rom_byte(input logic [ADDR_W-1:0] a);
        case (a)
            ROM_FMT_ADDR: return 8'h31;
            ROM_PHS_ADDR: return 8'h55;
            default:      return 8'h00;
        endcase
    endfunction

    function automatic logic [7:0] summary_pack(input logic rst_f,
                                                input logic err_f,
                                                input logic [4:0] flg);
        logic [6:0] low;
        low = {rst_f, err_f, flg};
        return {~|low, low};
    endfunction

endpackage

// File: rtl/spi_rsb_sync.sv
module spi_rsb_sync #(
    parameter int          W      = 3,
    parameter int          STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    logic [W-1:0] pipe_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk) begin
                if (rst) pipe_q[s] <= RST_VAL;
                else if (s == 0) pipe_q[s] <= d_i;
                else pipe_q[s] <= pipe_q[(s == 0) ? 0 : s-1];
            end
        end
    endgenerate

    assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/spi_rsb_frame.sv
module spi_rsb_frame
    import spi_rsb_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             csn_s,
    input  logic             sck_s,
    input  logic             sdi_s,
    input  logic [7:0]       gsb_i,
    input  logic [REG_W-1:0] resp_i,
    output cmd_t             cmd_o,
    output logic             commit_o,
    output logic             ok_o,
    output cmd_t             fcmd_o,
    output logic [REG_W-1:0] fdata_o,
    output logic             sdo_o,
    output logic             sdo_oe_o
);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
    localparam logic [CNT_W-1:0] CNT_OVER = CNT_W'(FRAME_W + 1);
    localparam logic [CNT_W-1:0] CNT_HDR  = CNT_W'(7);

    logic               csn_d, sck_d;
    logic [FRAME_W-1:0] rx_q, tx_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [7:0]         gsb_q;
    logic               ld_q;
    logic               csn_fall, csn_rise, sck_rise, sck_fall;

    assign csn_fall = csn_d & ~csn_s;
    assign csn_rise = ~csn_d & csn_s;
    assign sck_rise = ~csn_s & sck_s & ~sck_d;
    assign sck_fall = ~csn_s & ~sck_s & sck_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            csn_d <= 1'b1;
            sck_d <= 1'b0;
            rx_q  <= '0;
            tx_q  <= '0;
            cnt_q <= '0;
            gsb_q <= '0;
            ld_q  <= 1'b0;
        end else begin
            csn_d <= csn_s;
            sck_d <= sck_s;
            ld_q  <= 1'b0;
            if (csn_fall) begin
                rx_q  <= '0;
                cnt_q <= '0;
                gsb_q <= gsb_i;
                tx_q  <= {gsb_i, {(FRAME_W-8){1'b0}}};
            end else begin
                if (sck_rise) begin
                    rx_q <= {rx_q[FRAME_W-2:0], sdi_s};
                    if (cnt_q != CNT_OVER) cnt_q <= cnt_q + 1'b1;
                    ld_q <= (cnt_q == CNT_HDR);
                end
                if (ld_q) begin
                    tx_q[FRAME_W-2:FRAME_W-25] <= {resp_i, ~^{gsb_q, resp_i}};
                end else if (sck_fall) begin
                    tx_q <= {tx_q[FRAME_W-2:0], 1'b0};
                end
            end
        end
    end

    assign cmd_o    = cmd_t'(rx_q[7:0]);
    assign fcmd_o   = cmd_t'(rx_q[31:24]);
    assign fdata_o  = rx_q[23:1];
    assign commit_o = csn_rise;
    assign ok_o     = (cnt_q == CNT_FULL) && (^rx_q) && (rx_q[23:0] != '1);
    assign sdo_oe_o = ~csn_s;
    assign sdo_o    = tx_q[FRAME_W-1] & ~csn_s;

    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (rst)
        cnt_q <= CNT_OVER) else $error("bit counter past saturation"); // R8
    AST_LOAD_AFTER_CMD: assert property (@(posedge clk) disable iff (rst)
        ld_q |-> cnt_q == CNT_W'(8)) else $error("response load off byte"); // R3
    AST_OE_IDLE: assert property (@(posedge clk) disable iff (rst)
        csn_s |-> !sdo_o) else $error("sdo driven while deselected"); // R9
endmodule

// File: rtl/spi_rsb_regs.sv
module spi_rsb_regs
    import spi_rsb_pkg::*;
#(
    parameter int NUM_CTRL = 3,
    parameter int NUM_STAT = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  cmd_t                         cmd_i,
    input  logic                         commit_i,
    input  logic                         ok_i,
    input  cmd_t                         fcmd_i,
    input  logic [REG_W-1:0]             fdata_i,
    input  logic [4:0]                   flags_i,
    input  logic [NUM_STAT*REG_W-1:0]    stat_set_i,
    output logic [NUM_CTRL*REG_W-1:0]    ctrl_o,
    output logic [NUM_STAT*REG_W-1:0]    stat_o,
    output logic [NUM_STAT-1:0]          stat_clr_o,
    output logic [7:0]                   gsb_o,
    output logic [REG_W-1:0]             resp_o
);
    localparam int STAT_BASE = NUM_CTRL + 1;

    logic [NUM_CTRL-1:0][REG_W-1:0] ctrl_q;
    logic [NUM_STAT-1:0][REG_W-1:0] stat_q;
    logic [NUM_STAT-1:0][REG_W-1:0] set_v;
    logic                           rst_flag_q, err_flag_q;
    logic [NUM_CTRL-1:0]            rd_ctrl_hit, wr_ctrl_hit;
    logic [NUM_STAT-1:0]            rd_stat_hit, clr_hit;
    logic                           valid_commit;

    assign valid_commit = commit_i & ok_i;
    assign set_v        = stat_set_i;

    genvar i;
    generate
        for (i = 0; i < NUM_CTRL; i++) begin : g_ctrl_dec
            assign rd_ctrl_hit[i] = (cmd_i.addr == ADDR_W'(i + 1));
            assign wr_ctrl_hit[i] = valid_commit && fcmd_i.op == OP_WRITE &&
                                    fcmd_i.addr == ADDR_W'(i + 1);
        end
        for (i = 0; i < NUM_STAT; i++) begin : g_stat_dec
            assign rd_stat_hit[i] = (cmd_i.addr == ADDR_W'(STAT_BASE + i));
            assign clr_hit[i]     = valid_commit && fcmd_i.op == OP_RDCLR &&
                                    (fcmd_i.addr == ADDR_W'(STAT_BASE + i) ||
                                     fcmd_i.addr == ADDR_CLR_ALL);
        end
    endgenerate

    always_comb begin
        resp_o = '0;
        if (cmd_i.op == OP_ROMRD) begin
            resp_o = {rom_byte(cmd_i.addr), {(REG_W-8){1'b0}}};
        end else begin
            for (int k = 0; k < NUM_CTRL; k++)
                if (rd_ctrl_hit[k]) resp_o = ctrl_q[k];
            for (int k = 0; k < NUM_STAT; k++)
                if (rd_stat_hit[k]) resp_o = stat_q[k];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q     <= '0;
            stat_q     <= '0;
            rst_flag_q <= 1'b1;
            err_flag_q <= 1'b0;
        end else begin
            if (commit_i) begin
                if (ok_i) begin
                    rst_flag_q <= 1'b0;
                    err_flag_q <= 1'b0;
                end else begin
                    err_flag_q <= 1'b1;
                end
            end
            for (int k = 0; k < NUM_CTRL; k++)
                if (wr_ctrl_hit[k]) ctrl_q[k] <= fdata_i;
            for (int k = 0; k < NUM_STAT; k++)
                stat_q[k] <= (clr_hit[k] ? '0 : stat_q[k]) | set_v[k];
        end
    end

    assign ctrl_o     = ctrl_q;
    assign stat_o     = stat_q;
    assign stat_clr_o = clr_hit;
    assign gsb_o      = summary_pack(rst_flag_q, err_flag_q, flags_i);

    AST_BAD_FRAME_KEEPS_CTRL: assert property (@(posedge clk) disable iff (rst)
        commit_i && !ok_i |=> $stable(ctrl_q)) else $error("rejected frame wrote"); // R8
    AST_BAD_FRAME_FLAGS: assert property (@(posedge clk) disable iff (rst)
        commit_i && !ok_i |=> err_flag_q) else $error("error flag not raised"); // R8
    AST_RST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (rst)
        commit_i && ok_i |=> !rst_flag_q) else $error("reset flag stuck"); // R4
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (rst)
        !valid_commit && stat_set_i == '0 |=> $stable(stat_q)) else $error("status drifted"); // R10
    AST_CLR_ONLY_ON_FRAME: assert property (@(posedge clk) disable iff (rst)
        |stat_clr_o |-> valid_commit) else $error("stray clear strobe"); // R5
endmodule

// File: rtl/spi_status_regif.sv
module spi_status_regif
    import spi_rsb_pkg::*;
#(
    parameter int NUM_CTRL    = 3,
    parameter int NUM_STAT    = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      csn,
    input  logic                      sck,
    input  logic                      sdi,
    input  logic [4:0]                flags_i,
    input  logic [NUM_STAT*REG_W-1:0] stat_set_i,
    output logic                      sdo,
    output logic                      sdo_oe,
    output logic [NUM_CTRL*REG_W-1:0] ctrl_o,
    output logic [NUM_STAT*REG_W-1:0] stat_o,
    output logic [NUM_STAT-1:0]       stat_clr_o
);
    logic [2:0]       pins_s;
    cmd_t             cmd, fcmd;
    logic             commit, ok;
    logic [REG_W-1:0] fdata, resp;
    logic [7:0]       gsb;

    spi_rsb_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk(clk), .rst(rst), .d_i({csn, sck, sdi}), .q_o(pins_s)
    );

    spi_rsb_frame u_frame (
        .clk(clk), .rst(rst),
        .csn_s(pins_s[2]), .sck_s(pins_s[1]), .sdi_s(pins_s[0]),
        .gsb_i(gsb), .resp_i(resp),
        .cmd_o(cmd), .commit_o(commit), .ok_o(ok),
        .fcmd_o(fcmd), .fdata_o(fdata),
        .sdo_o(sdo), .sdo_oe_o(sdo_oe)
    );

    spi_rsb_regs #(.NUM_CTRL(NUM_CTRL), .NUM_STAT(NUM_STAT)) u_regs (
        .clk(clk), .rst(rst),
        .cmd_i(cmd), .commit_i(commit), .ok_i(ok),
        .fcmd_i(fcmd), .fdata_i(fdata),
        .flags_i(flags_i), .stat_set_i(stat_set_i),
        .ctrl_o(ctrl_o), .stat_o(stat_o), .stat_clr_o(stat_clr_o),
        .gsb_o(gsb), .resp_o(resp)
    );
endmodule

// File: tb/sim_spi_status_regif.sv
`timescale 1ns/1ps
module sim_spi_status_regif;
    localparam int NC = 2;
    localparam int NS = 3;
    localparam int HALF = 40;

    logic clk = 1'b0, rst = 1'b1, csn = 1'b1, sck = 1'b0, sdi = 1'b0;
    logic [4:0] flags = '0;
    logic [NS*23-1:0] sset = '0;
    logic sdo, sdo_oe;
    logic [NC*23-1:0] ctrl;
    logic [NS*23-1:0] stat;
    logic [NS-1:0] sclr;
    int checks = 0, fails = 0, cyc = 0, clr_pulses = 0;
    logic [31:0] r;
    logic oe_all;

    always #2 clk = ~clk;

    spi_status_regif #(.NUM_CTRL(NC), .NUM_STAT(NS)) u0 (
        .clk(clk), .rst(rst), .csn(csn), .sck(sck), .sdi(sdi),
        .flags_i(flags), .stat_set_i(sset), .sdo(sdo), .sdo_oe(sdo_oe),
        .ctrl_o(ctrl), .stat_o(stat), .stat_clr_o(sclr)
    );

    always @(posedge clk) begin
        cyc <= cyc + 1;
        clr_pulses <= clr_pulses + $countones(sclr);
        if (cyc > 200000) begin
            fails = fails + 1;
            $display("FAIL watchdog: act=timeout exp=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: act=%h exp=%h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [1:0] op, input logic [5:0] a,
                                       input logic [22:0] d);
        return {op, a, d, ~^{op, a, d}};
    endfunction

    task automatic xfer(input int nbits, input logic [31:0] w,
                        output logic [31:0] rsp, output logic oe);
        rsp = '0;
        oe  = 1'b1;
        csn = 1'b0;
        sdi = w[31];
        #HALF;
        for (int i = 0; i < nbits; i++) begin
            rsp[31-i] = sdo;
            oe = oe & sdo_oe;
            sck = 1'b1;
            #HALF;
            sck = 1'b0;
            if (i < 31) sdi = w[30-i];
            #HALF;
        end
        csn = 1'b1;
        #(HALF*2);
    endtask

    task automatic t_reset;
        chk("R9 oe idle", {31'b0, sdo_oe}, 32'h0);
        chk("R2 ctrl reset", ctrl[31:0], 32'h0);
        xfer(32, mk(2'b11, 6'h10, 23'h0), r, oe_all);
        chk("R4 reset flag in gsb", {24'b0, r[31:24]}, 32'h40);
        chk("R7 rom 10h", {24'b0, r[23:16]}, 32'h31);
        chk("R3 response parity", {31'b0, ^r}, 32'h1);
        chk("R9 oe during frame", {31'b0, oe_all}, 32'h1);
        xfer(32, mk(2'b11, 6'h20, 23'h0), r, oe_all);
        chk("R4 all-clear after valid frame", {24'b0, r[31:24]}, 32'h80);
        chk("R7 rom 20h", {24'b0, r[23:16]}, 32'h55);
        xfer(32, mk(2'b11, 6'h05, 23'h0), r, oe_all);
        chk("R7 rom other", {9'b0, r[23:1]}, 32'h0);
    endtask

    task automatic t_write;
        xfer(32, mk(2'b00, 6'h01, 23'h2A5A5A), r, oe_all);
        chk("R3 write returns old", {9'b0, r[23:1]}, 32'h0);
        chk("R2 ctrl1 stored", {9'b0, ctrl[22:0]}, 32'h2A5A5A);
        xfer(32, mk(2'b00, 6'h01, 23'h1234AB), r, oe_all);
        chk("R3 write returns prev", {9'b0, r[23:1]}, 32'h2A5A5A);
        chk("R3 write parity", {31'b0, ^r}, 32'h1);
        xfer(32, mk(2'b00, 6'h02, 23'h000777), r, oe_all);
        chk("R2 ctrl2 stored", {9'b0, ctrl[45:23]}, 32'h777);
        chk("R2 ctrl1 kept", {9'b0, ctrl[22:0]}, 32'h1234AB);
        xfer(32, mk(2'b01, 6'h02, 23'h0), r, oe_all);
        chk("R1 read ctrl2", {9'b0, r[23:1]}, 32'h777);
    endtask

    task automatic t_errors;
        xfer(32, mk(2'b00, 6'h01, 23'h000011) ^ 32'h1, r, oe_all);
        chk("R8 bad parity no write", {9'b0, ctrl[22:0]}, 32'h1234AB);
        xfer(32, mk(2'b01, 6'h01, 23'h0), r, oe_all);
        chk("R8 error flag after parity", {24'b0, r[31:24]}, 32'h20);
        xfer(31, mk(2'b00, 6'h01, 23'h000022), r, oe_all);
        chk("R8 short frame no write", {9'b0, ctrl[22:0]}, 32'h1234AB);
        xfer(32, 32'h01FF_FFFF, r, oe_all);
        chk("R8 stuck data no write", {9'b0, ctrl[22:0]}, 32'h1234AB);
        xfer(32, mk(2'b01, 6'h01, 23'h0), r, oe_all);
        chk("R8 error flag after stuck", {24'b0, r[31:24]}, 32'h20);
        xfer(32, mk(2'b01, 6'h01, 23'h0), r, oe_all);
        chk("R8 error flag cleared", {24'b0, r[31:24]}, 32'h80);
    endtask

    task automatic t_flags;
        flags = 5'b00001;
        xfer(32, mk(2'b01, 6'h01, 23'h0), r, oe_all);
        chk("R4 fail-safe bit", {24'b0, r[31:24]}, 32'h01);
        flags = 5'b10000;
        xfer(32, mk(2'b01, 6'h01, 23'h0), r, oe_all);
        chk("R4 bit28 mirror", {24'b0, r[31:24]}, 32'h10);
        flags = '0;
    endtask

    task automatic t_status;
        int base;
        base = clr_pulses;
        sset[22:0]  = 23'h000105;
        sset[45:23] = 23'h000030;
        sset[68:46] = 23'h400000;
        @(posedge clk); #1;
        sset = '0;
        #(HALF);
        chk("R10 sticky set", {9'b0, stat[22:0]}, 32'h105);
        xfer(32, mk(2'b01, 6'h03, 23'h0), r, oe_all);
        chk("R5 plain read value", {9'b0, r[23:1]}, 32'h105);
        chk("R5 plain read keeps", {9'b0, stat[22:0]}, 32'h105);
        xfer(32, mk(2'b10, 6'h03, 23'h0), r, oe_all);
        chk("R5 rc returns value", {9'b0, r[23:1]}, 32'h105);
        chk("R5 rc clears", {9'b0, stat[22:0]}, 32'h0);
        chk("R5 neighbour kept", {9'b0, stat[45:23]}, 32'h30);
        chk("R5 one strobe", clr_pulses - base, 32'h1);
        xfer(32, mk(2'b10, 6'h3F, 23'h0), r, oe_all);
        chk("R6 clear all s1", {9'b0, stat[45:23]}, 32'h0);
        chk("R6 clear all s2", {9'b0, stat[68:46]}, 32'h0);
        chk("R6 strobes", clr_pulses - base, 32'h4);
    endtask

    task automatic t_unmapped;
        xfer(32, mk(2'b00, 6'h30, 23'h00ABCD), r, oe_all);
        chk("R11 unmapped read zero", {9'b0, r[23:1]}, 32'h0);
        chk("R11 ctrl1 unchanged", {9'b0, ctrl[22:0]}, 32'h1234AB);
        chk("R11 ctrl2 unchanged", {9'b0, ctrl[45:23]}, 32'h777);
        xfer(32, mk(2'b00, 6'h03, 23'h00ABCD), r, oe_all);
        chk("R11 write to status ignored", {9'b0, stat[22:0]}, 32'h0);
    endtask

    initial begin
        repeat (10) @(negedge clk);
        rst = 1'b0;
        #(HALF);
        t_reset();
        t_write();
        t_errors();
        t_flags();
        t_status();
        t_unmapped();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule